// File: doc/BRIEF.md
# DRAM Activate Rate Limiter

This block decides, in each DRAM clock, whether a requested row-activate command for a single rank may be placed on the command bus. It limits activates in two ways, because each activate draws a burst of supply current. The first limit is a minimum number of clocks between any two activates, whichever banks they target. The second limit is a rolling window in which at most four activates may issue. Both limits come from small encoded fields in a configuration word, not from plain cycle counts.

The grant is combinational. In the cycle a request is made, the grant is asserted if every rule allows it, and the internal timers move on that same clock edge. Other command sources on the shared bus report when they start a command, and the block keeps the bus reserved for the configured command length. The configuration word is sampled only in cycles with no request pending. If a sampled code is reserved, the block enters a fault state, raises an error flag and grants nothing until a valid word is sampled.

Control is a three-state machine:
- ST_OPEN: grants are possible.
- ST_HELD: a multi-clock command still occupies the bus.
- ST_FAULT: a reserved code is loaded.

Transitions:
- OPEN→HELD: a command starts and its length is more than one clock.
- HELD→OPEN: the remaining hold count reaches its last clock.
- HELD→HELD: a new command starts during a hold, and the hold restarts.
- OPEN/HELD→FAULT: a reserved word is sampled.
- FAULT→OPEN: a valid word is sampled.

Reset samples the configuration word directly. It enters FAULT if that word is reserved and OPEN otherwise.

Top module: `dram_act_limiter`

## Requirements
- R1: The spacing code in cfg_word[1:0] sets the minimum distance between two grants. Codes 0, 1, 2 and 3 give 4, 5, 6 and 7 clocks. With the request held high, the second grant comes exactly that many cycles after the first.
- R2: No more than four grants occur within any span of W clocks. A fifth grant is allowed only when the grant four back is at least W cycles old.
- R3: The window code in cfg_word[5:2] sets W = 2·code + 10 clocks for codes 2 to 12, which gives 14 to 34 clocks.
- R4: Window codes 0, 1 and 13 to 15 are reserved. Command-length code 3 is also reserved. Sampling any reserved code, either at reset or during operation, sets cfg_err in the next cycle and blocks every grant. Both hold until a valid word is sampled, which clears cfg_err; a request in the following cycle is then granted.
- R5: The command-length code in cfg_word[7:6] gives a command length L of 1, 2 or 3 clocks for codes 0, 1 and 2. No grant is given in a cycle where bus_cmd_start is high, nor in the L−1 cycles after it. A pending request is granted L cycles after the start.
- R6: cfg_word is sampled only on clock edges where act_req is low, and it takes effect from the next cycle. Changes made while a request is held have no effect on grants or on cfg_err.
- R7: act_grant is high only in a cycle where act_req is high. It responds combinationally in that same cycle.
- R8: After reset with a valid word, cfg_err is low and the first request is granted in the cycle it is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 8 | Encoded fields: [1:0] spacing, [5:2] window, [7:6] command length |
| act_req | input | 1 | An activate is waiting to issue |
| bus_cmd_start | input | 1 | Another command source starts a command this cycle |
| act_grant | output | 1 | The activate may issue this cycle |
| cfg_err | output | 1 | A reserved code is loaded and grants are blocked |

## Verification
A wrong age in the activate history shows at the ports as the fifth grant in a burst coming too early or too late. The error is seen one window length after the fourth grant, which is at most 34 clocks. A fault in the spacing counter or the hold counter changes the distance between two grants, or between a bus start and the next grant. That error is seen within seven clocks. A wrong fault state shows at once on cfg_err, and it also shows as a grant that should or should not have been blocked in the very next requested cycle.

// File: rtl/dar_pkg.sv
package dar_pkg;

    localparam int SPACE_W = 2;
    localparam int WIN_W   = 4;
    localparam int MODE_W  = 2;
    localparam int CFG_W   = SPACE_W + WIN_W + MODE_W;

    localparam logic [WIN_W-1:0]  WIN_CODE_MIN  = WIN_W'(2);
    localparam logic [WIN_W-1:0]  WIN_CODE_MAX  = WIN_W'(12);
    localparam logic [MODE_W-1:0] MODE_CODE_MAX = MODE_W'(2);

    // Field order matches cfg_word bit positions: mode [7:6], win [5:2], space [1:0]
    typedef struct packed {
        logic [MODE_W-1:0]  mode;
        logic [WIN_W-1:0]   win;
        logic [SPACE_W-1:0] space;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_HELD  = 2'd1,
        ST_FAULT = 2'd2
    } lim_state_e;

    function automatic logic cfg_reserved(input cfg_t c);
        return (c.win < WIN_CODE_MIN) || (c.win > WIN_CODE_MAX) ||
               (c.mode > MODE_CODE_MAX);
    endfunction

endpackage

// File: rtl/dar_decode.sv
module dar_decode
    import dar_pkg::*;
#(
    parameter int AGE_W = 6
) (
    input  cfg_t              cfg,
    output logic [AGE_W-1:0]  gap_clks,
    output logic [AGE_W-1:0]  win_clks,
    output logic [MODE_W-1:0] hold_clks
);

    localparam int GAP_BASE = 4;
    localparam int WIN_BASE = 10;

    always_comb begin
        gap_clks  = AGE_W'(cfg.space) + AGE_W'(GAP_BASE);
        win_clks  = AGE_W'({cfg.win, 1'b0}) + AGE_W'(WIN_BASE);
        hold_clks = cfg.mode + MODE_W'(1);
    end

endmodule

// File: rtl/dar_gap_timer.sv
module dar_gap_timer #(
    parameter int AGE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [AGE_W-1:0] limit,
    output logic             ok
);

    localparam logic [AGE_W-1:0] AGE_SAT = '1;

    logic [AGE_W-1:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= AGE_SAT;
        end else if (fire) begin
            since_q <= AGE_W'(1);
        end else if (since_q != AGE_SAT) begin
            since_q <= since_q + AGE_W'(1);
        end
    end

    assign ok = (since_q >= limit);

endmodule

// File: rtl/dar_act_history.sv
module dar_act_history #(
    parameter int NUM_ACT = 4,
    parameter int AGE_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [AGE_W-1:0] limit,
    output logic             ok
);

    localparam logic [AGE_W-1:0] AGE_SAT = '1;

    logic [AGE_W-1:0] age_q [NUM_ACT];

    function automatic logic [AGE_W-1:0] sat_inc(input logic [AGE_W-1:0] a);
        return (a == AGE_SAT) ? a : a + AGE_W'(1);
    endfunction

    // Slot 0 holds the newest activate, slot NUM_ACT-1 the oldest of the set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ACT; i++) age_q[i] <= AGE_SAT;
        end else if (fire) begin
            age_q[0] <= AGE_W'(1);
            for (int i = 1; i < NUM_ACT; i++) age_q[i] <= sat_inc(age_q[i-1]);
        end else begin
            for (int i = 0; i < NUM_ACT; i++) age_q[i] <= sat_inc(age_q[i]);
        end
    end

    assign ok = (age_q[NUM_ACT-1] >= limit);

endmodule

// File: rtl/dram_act_limiter.sv
module dram_act_limiter
    import dar_pkg::*;
#(
    parameter int NUM_ACT = 4,
    parameter int AGE_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             act_req,
    input  logic             bus_cmd_start,
    output logic             act_grant,
    output logic             cfg_err
);

    cfg_t              cfg_in;
    cfg_t              cfg_q;
    logic              cfg_load;
    logic              in_bad;
    lim_state_e        state_q, state_d;
    logic [MODE_W-1:0] rem_q, rem_d;
    logic [AGE_W-1:0]  gap_clks, win_clks;
    logic [MODE_W-1:0] hold_clks;
    logic              gap_ok, win_ok, bus_start, long_cmd;

    assign cfg_in    = cfg_t'(cfg_word);
    assign cfg_load  = !act_req;
    assign in_bad    = cfg_reserved(cfg_in);
    assign bus_start = bus_cmd_start | act_grant;
    assign long_cmd  = (hold_clks > MODE_W'(1));

    dar_decode #(.AGE_W(AGE_W)) u_decode (
        .cfg       (cfg_q),
        .gap_clks  (gap_clks),
        .win_clks  (win_clks),
        .hold_clks (hold_clks)
    );

    dar_gap_timer #(.AGE_W(AGE_W)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (act_grant),
        .limit (gap_clks),
        .ok    (gap_ok)
    );

    dar_act_history #(.NUM_ACT(NUM_ACT), .AGE_W(AGE_W)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (act_grant),
        .limit (win_clks),
        .ok    (win_ok)
    );

    // Configuration register: sampled only while no activate is pending
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_load) begin
            cfg_q <= cfg_in;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= in_bad ? ST_FAULT : ST_OPEN;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        unique case (state_q)
            ST_FAULT: begin
                if (cfg_load && !in_bad) state_d = ST_OPEN;
            end
            ST_OPEN: begin
                if (cfg_load && in_bad) begin
                    state_d = ST_FAULT;
                end else if (bus_start && long_cmd) begin
                    state_d = ST_HELD;
                    rem_d   = hold_clks - MODE_W'(1);
                end
            end
            ST_HELD: begin
                if (cfg_load && in_bad) begin
                    state_d = ST_FAULT;
                end else if (bus_start) begin
                    state_d = long_cmd ? ST_HELD : ST_OPEN;
                    rem_d   = hold_clks - MODE_W'(1);
                end else if (rem_q == MODE_W'(1)) begin
                    state_d = ST_OPEN;
                end else begin
                    rem_d = rem_q - MODE_W'(1);
                end
            end
            default: state_d = ST_FAULT;
        endcase
    end

    // Outputs
    always_comb begin
        act_grant = act_req && !bus_cmd_start && (state_q == ST_OPEN) &&
                    gap_ok && win_ok;
        cfg_err   = (state_q == ST_FAULT);
    end

endmodule

// File: rtl/dram_act_limiter_chk.sv
module dram_act_limiter_chk (
    input logic clk,
    input logic rst_n,
    input logic act_req,
    input logic bus_cmd_start,
    input logic act_grant,
    input logic cfg_err
);

    logic live_q;

    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    p_grant_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_grant |-> act_req);

    p_fault_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !act_grant);

    p_bus_start_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_start |-> !act_grant);

    p_gap_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
        act_grant |=> !act_grant);

    p_gap_two_r1: assert property (@(posedge clk) disable iff (!rst_n)
        act_grant |-> ##2 !act_grant);

    p_gap_three_r1: assert property (@(posedge clk) disable iff (!rst_n)
        act_grant |-> ##3 !act_grant);

    p_err_change_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && (cfg_err != $past(cfg_err))) |-> !$past(act_req));

endmodule

bind dram_act_limiter dram_act_limiter_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .act_req       (act_req),
    .bus_cmd_start (bus_cmd_start),
    .act_grant     (act_grant),
    .cfg_err       (cfg_err)
);

// File: tb/tb_dram_act_limiter.sv
`timescale 1ns/1ps
module tb_dram_act_limiter;
    import dar_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             act_req = 1'b0;
    logic             bus_cmd_start = 1'b0;
    logic [CFG_W-1:0] cfg_word = '0;
    logic             act_grant;
    logic             cfg_err;

    int checks = 0;
    int fails  = 0;
    int tg [0:7];

    always #2.5 clk = ~clk;

    dram_act_limiter dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_word      (cfg_word),
        .act_req       (act_req),
        .bus_cmd_start (bus_cmd_start),
        .act_grant     (act_grant),
        .cfg_err       (cfg_err)
    );

    function automatic logic [CFG_W-1:0] mk(input int mode, input int win, input int sp);
        return {2'(mode), 4'(win), 2'(sp)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [CFG_W-1:0] cfg);
        @(negedge clk);
        rst_n = 1'b0; act_req = 1'b0; bus_cmd_start = 1'b0; cfg_word = cfg;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle: drive at a falling edge, sample 1 ns later, then wait for the next falling edge
    task automatic step(input bit req, input bit st, output bit g);
        act_req = req; bus_cmd_start = st;
        #1 g = act_grant;
        @(negedge clk);
    endtask

    task automatic collect(input int want, input int limit);
        int n = 0;
        bit g;
        for (int c = 0; c < limit && n < want; c++) begin
            step(1'b1, 1'b0, g);
            if (g) begin tg[n] = c; n++; end
        end
        for (int k = n; k < 8; k++) tg[k] = -1;
        act_req = 1'b0;
    endtask

    task automatic t_reset_r8();
        bit g;
        do_reset(mk(0, 9, 0));
        #1 chk(cfg_err == 1'b0, "R8 err after reset", cfg_err, 0);
        chk(act_grant == 1'b0, "R7 no grant without request", act_grant, 0);
        step(1'b1, 1'b0, g);
        chk(g == 1'b1, "R8 first request granted", g, 1);
        act_req = 1'b0;
    endtask

    task automatic t_spacing_r1();
        for (int sp = 0; sp < 4; sp++) begin
            do_reset(mk(0, 12, sp));
            collect(2, 40);
            chk(tg[1] - tg[0] == sp + 4, "R1 spacing", tg[1] - tg[0], sp + 4);
        end
    endtask

    task automatic t_window_r2_r3();
        int codes [4] = '{2, 5, 9, 12};
        for (int i = 0; i < 4; i++) begin
            int w  = 2 * codes[i] + 10;
            int e5 = (w > 16) ? w : 16;
            int e6 = (e5 + 4 > w + 4) ? e5 + 4 : w + 4;
            do_reset(mk(0, codes[i], 0));
            collect(6, 80);
            chk(tg[3] == 12, "R2 fourth grant", tg[3], 12);
            chk(tg[4] == e5, "R3 fifth grant at window", tg[4], e5);
            chk(tg[5] == e6, "R2 sixth grant", tg[5], e6);
        end
    endtask

    task automatic t_reserved_r4();
        logic [CFG_W-1:0] bad [5];
        bit g;
        bad[0] = mk(0, 0, 0); bad[1] = mk(0, 1, 0); bad[2] = mk(0, 13, 1);
        bad[3] = mk(0, 15, 3); bad[4] = mk(3, 9, 0);
        for (int i = 0; i < 5; i++) begin
            do_reset(mk(0, 9, 0));
            cfg_word = bad[i];
            step(1'b0, 1'b0, g);
            #1 chk(cfg_err == 1'b1, "R4 err raised", cfg_err, 1);
            for (int k = 0; k < 4; k++) begin
                step(1'b1, 1'b0, g);
                chk(g == 1'b0, "R4 grant blocked", g, 0);
            end
            cfg_word = mk(0, 9, 0);
            step(1'b0, 1'b0, g);
            #1 chk(cfg_err == 1'b0, "R4 err cleared", cfg_err, 0);
            step(1'b1, 1'b0, g);
            chk(g == 1'b1, "R4 grant after valid", g, 1);
            act_req = 1'b0;
        end
        do_reset(mk(3, 9, 0));
        #1 chk(cfg_err == 1'b1, "R4 reserved at reset", cfg_err, 1);
    endtask

    task automatic t_hold_r5();
        bit g;
        for (int m = 0; m < 3; m++) begin
            do_reset(mk(m, 9, 0));
            step(1'b1, 1'b1, g);
            chk(g == 1'b0, "R5 start cycle blocked", g, 0);
            for (int k = 0; k < m; k++) begin
                step(1'b1, 1'b0, g);
                chk(g == 1'b0, "R5 hold blocked", g, 0);
            end
            step(1'b1, 1'b0, g);
            chk(g == 1'b1, "R5 grant after hold", g, 1);
            act_req = 1'b0;
        end
    endtask

    task automatic t_cfg_gate_r6();
        bit g;
        do_reset(mk(0, 12, 3));
        cfg_word = mk(0, 12, 0);
        collect(2, 40);
        chk(tg[1] - tg[0] == 7, "R6 change under request ignored", tg[1] - tg[0], 7);
        cfg_word = mk(3, 0, 0);
        act_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 1'b0, g);
            #1 chk(cfg_err == 1'b0, "R6 reserved under request ignored", cfg_err, 0);
        end
        step(1'b0, 1'b0, g);
        #1 chk(cfg_err == 1'b1, "R6 sampled when idle", cfg_err, 1);
        cfg_word = mk(0, 12, 0);
        step(1'b0, 1'b0, g);
        collect(2, 40);
        chk(tg[1] - tg[0] == 4, "R6 new spacing applied", tg[1] - tg[0], 4);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset_r8();
        t_spacing_r1();
        t_window_r2_r3();
        t_reserved_r4();
        t_hold_r5();
        t_cfg_gate_r6();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule